// File: doc/BRIEF.md
# Dual Data Pointer Register Bank

This block keeps two independent 16-bit data pointers for an 8-bit microcontroller core. An external select input picks one of them as the active pointer. All pointer traffic reaches only the active copy. This covers byte-wide special-function-register reads and writes, 16-bit loads and increments from the core datapath, and the address the core drives for external-data and code-constant fetches. The copy that is not selected keeps its value.

Software reaches the active pointer through two byte addresses on the special-function-register bus. The core datapath sees the same register as a single 16-bit value. The select bit itself lives elsewhere, and this block does not save or restore it. When software switches between pointers, it must keep track of the select bit itself.

Top module: `dual_dptr_bank`

## Requirements
- R1: Address 82h maps to the low byte (bits 7:0) and address 83h maps to the high byte (bits 15:8) of the active pointer. A bus write to one of them changes only that byte.
- R2: On a clock edge with `rst_n` low, both pointer copies become 0000h.
- R3: A pulse on `ld_en` writes `ld_data` into the whole active pointer at the next clock edge.
- R4: `sfr_rdata` returns the addressed byte of the active pointer in the same cycle, with no wait cycle. Any address other than 82h or 83h reads as 00h.
- R5: Loads, byte writes and increments never change the copy that is not selected.
- R6: With `dp_sel` = 0, copy 0 is active. With `dp_sel` = 1, copy 1 is active.
- R7: A pulse on `inc_en` adds one to the active pointer as a 16-bit value. The carry passes from the low byte to the high byte, and FFFFh wraps to 0000h.
- R8: When `ld_en` and a pointer byte write fall in the same cycle, the 16-bit load takes effect and the byte write is dropped.
- R9: An increment in the same cycle as a load or a pointer byte write is dropped.
- R10: Bus writes to addresses other than 82h and 83h leave both pointers unchanged.
- R11: `dp_addr` always shows the active copy. It follows `dp_sel` combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | Special-function-register bus address |
| sfr_wdata | input | 8 | Bus write data |
| sfr_we | input | 1 | Bus write strobe |
| sfr_rdata | output | 8 | Bus read data for the addressed pointer byte |
| ld_en | input | 1 | 16-bit load strobe from the datapath |
| ld_data | input | 16 | 16-bit load value |
| inc_en | input | 1 | 16-bit increment strobe |
| dp_sel | input | 1 | Active pointer select |
| dp_addr | output | 16 | Active pointer value, used as the memory address |

## Verification
The assertions check the following on every cycle, inside each copy: reset clears it, a load lands whole, a byte write touches one byte only, an increment adds one, and an unselected copy holds its value. At the top level, they also check that each byte read agrees with the matching half of the address output. The bench scenarios cover the rest. These include what happens to the other copy after the select flips, the carry from low to high byte and the wrap at FFFFh, the priority between simultaneous strobes, writes to other addresses being ignored, and the address output following the select input with no clock edge.

// File: rtl/dptr_pkg.sv
// Package: shared widths and the byte-lane type for the data pointer bank.
// Assumes an 8-bit register bus and pointers made of whole bytes.
package dptr_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_BYTES = 2;
    localparam int PTR_W = BYTE_W * PTR_BYTES;

    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Per-copy byte write strobes decoded from the bus.
    typedef struct packed {
        logic hi;
        logic lo;
    } lane_we_t;
endpackage

// File: rtl/dptr_sfr_decode.sv
// Module: decodes the register bus address into low and high byte hits
// and the matching write strobes.
// Assumes the two pointer byte addresses differ from each other.
module dptr_sfr_decode
    import dptr_pkg::*;
#(
    parameter logic [7:0] LO_ADDR = 8'h82,
    parameter logic [7:0] HI_ADDR = 8'h83
) (
    input  logic [7:0] addr,
    input  logic       we,
    output logic       lo_hit,
    output logic       hi_hit,
    output lane_we_t   lane_we
);
    // Address compare and write strobe gating.
    always_comb begin
        lo_hit     = (addr == LO_ADDR);
        hi_hit     = (addr == HI_ADDR);
        lane_we.lo = we && lo_hit;
        lane_we.hi = we && hi_hit;
    end
endmodule

// File: rtl/dptr_copy.sv
// Module: one 16-bit pointer copy. It updates only while enabled.
// Priority: 16-bit load, then byte writes, then increment.
// Assumes the enable is driven from the select decode.
module dptr_copy
    import dptr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     ld,
    input  ptr_t     ld_val,
    input  lane_we_t lane_we,
    input  byte_t    wdata,
    input  logic     inc,
    output ptr_t     q
);
    ptr_t nxt;

    // Next-value selection by priority.
    always_comb begin
        nxt = q;
        if (en) begin
            if (ld) begin
                nxt = ld_val;
            end else if (lane_we.lo || lane_we.hi) begin
                if (lane_we.lo) nxt[BYTE_W-1:0] = wdata;
                if (lane_we.hi) nxt[PTR_W-1:BYTE_W] = wdata;
            end else if (inc) begin
                nxt = q + ptr_t'(1);
            end
        end
    end

    // Pointer register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    assert_reset_R2: assert property (@(posedge clk)
        $rose(rst_n) |-> (q == '0));

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ld) |=> (q == $past(ld_val)));

    assert_hold_unsel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));

    assert_lo_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ld && lane_we.lo && !lane_we.hi) |=>
        (q[BYTE_W-1:0] == $past(wdata) && q[PTR_W-1:BYTE_W] == $past(q[PTR_W-1:BYTE_W])));

    assert_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && inc && !ld && !lane_we.lo && !lane_we.hi) |=> (q == $past(q) + ptr_t'(1)));
endmodule

// File: rtl/dptr_read_mux.sv
// Module: selects the active copy for the address output and for byte reads.
// Purely combinational. Assumes sel stays below the copy count.
module dptr_read_mux
    import dptr_pkg::*;
#(
    parameter int NUM_PTR = 2,
    localparam int SEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  ptr_t [NUM_PTR-1:0] copies,
    input  logic [SEL_W-1:0]   sel,
    input  logic               lo_hit,
    input  logic               hi_hit,
    output ptr_t               addr_out,
    output byte_t              rdata
);
    byte_t lo_byte;
    byte_t hi_byte;

    // Word and per-lane byte selection.
    always_comb begin
        addr_out = '0;
        lo_byte  = '0;
        hi_byte  = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (sel == SEL_W'(i)) begin
                addr_out = copies[i];
                lo_byte  = copies[i][BYTE_W-1:0];
                hi_byte  = copies[i][PTR_W-1:BYTE_W];
            end
        end
    end

    // Read data by address hit; other addresses read zero.
    always_comb begin
        if (lo_hit)      rdata = lo_byte;
        else if (hi_hit) rdata = hi_byte;
        else             rdata = '0;
    end
endmodule

// File: rtl/dual_dptr_bank.sv
// Module: top of the dual data pointer bank. Two copies sit behind one
// register address pair, and the select input steers every access.
// Assumes the select bit is held in another register outside this block.
module dual_dptr_bank
    import dptr_pkg::*;
#(
    parameter int         NUM_PTR = 2,
    parameter logic [7:0] LO_ADDR = 8'h82,
    parameter logic [7:0] HI_ADDR = 8'h83,
    localparam int        SEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    input  logic              sfr_we,
    output logic [7:0]        sfr_rdata,
    input  logic              ld_en,
    input  logic [15:0]       ld_data,
    input  logic              inc_en,
    input  logic [SEL_W-1:0]  dp_sel,
    output logic [15:0]       dp_addr
);
    logic              lo_hit;
    logic              hi_hit;
    lane_we_t          lane_we;
    ptr_t [NUM_PTR-1:0] copies;

    dptr_sfr_decode #(.LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_dec (
        .addr    (sfr_addr),
        .we      (sfr_we),
        .lo_hit  (lo_hit),
        .hi_hit  (hi_hit),
        .lane_we (lane_we)
    );

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_copy
        dptr_copy u_copy (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (dp_sel == SEL_W'(g)),
            .ld      (ld_en),
            .ld_val  (ld_data),
            .lane_we (lane_we),
            .wdata   (sfr_wdata),
            .inc     (inc_en),
            .q       (copies[g])
        );
    end

    dptr_read_mux #(.NUM_PTR(NUM_PTR)) u_mux (
        .copies   (copies),
        .sel      (dp_sel),
        .lo_hit   (lo_hit),
        .hi_hit   (hi_hit),
        .addr_out (dp_addr),
        .rdata    (sfr_rdata)
    );

    assert_rd_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == LO_ADDR) |-> (sfr_rdata == dp_addr[7:0]));

    assert_rd_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == HI_ADDR) |-> (sfr_rdata == dp_addr[15:8]));

    assert_rd_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr != LO_ADDR && sfr_addr != HI_ADDR) |-> (sfr_rdata == 8'h00));
endmodule

// File: tb/tb_dual_dptr_bank.sv
// Bench: a scoreboard. Driver tasks apply operations, update a reference
// model and push expected items. A monitor pops and compares them at
// each falling edge.
module tb_dual_dptr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_rdata;
    logic        ld_en = 1'b0;
    logic [15:0] ld_data = 16'h0000;
    logic        inc_en = 1'b0;
    logic [0:0]  dp_sel = 1'b0;
    logic [15:0] dp_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_rd;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    logic [15:0] mdl [2];

    always #5 clk = ~clk;

    dual_dptr_bank dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .ld_en(ld_en), .ld_data(ld_data),
        .inc_en(inc_en), .dp_sel(dp_sel), .dp_addr(dp_addr)
    );

    // Monitor: compare queued expectations away from the rising edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            act = it.is_rd ? {8'h00, sfr_rdata} : dp_addr;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic push_ptr(input string req);
        item_t it;
        it.is_rd = 0; it.exp = mdl[dp_sel]; it.req = req;
        sb.push_back(it);
    endtask

    task automatic push_rd(input logic [7:0] a, input string req);
        item_t it;
        @(posedge clk); #1;
        sfr_addr = a;
        it.is_rd = 1;
        it.exp = (a == 8'h82) ? {8'h00, mdl[dp_sel][7:0]} :
                 (a == 8'h83) ? {8'h00, mdl[dp_sel][15:8]} : 16'h0000;
        it.req = req;
        sb.push_back(it);
    endtask

    // One clocked operation; the model uses the documented priority.
    task automatic do_op(input bit ld, input logic [15:0] lv, input bit we,
                         input logic [7:0] a, input logic [7:0] wd, input bit inc);
        @(posedge clk); #1;
        ld_en = ld; ld_data = lv; sfr_we = we; sfr_addr = a; sfr_wdata = wd; inc_en = inc;
        @(posedge clk); #1;
        ld_en = 0; sfr_we = 0; inc_en = 0; sfr_addr = 8'h00;
        if (ld) mdl[dp_sel] = lv;
        else if (we && (a == 8'h82 || a == 8'h83)) begin
            if (a == 8'h82) mdl[dp_sel][7:0] = wd;
            else mdl[dp_sel][15:8] = wd;
        end else if (inc) mdl[dp_sel] = mdl[dp_sel] + 16'h1;
    endtask

    task automatic set_sel(input bit s);
        @(posedge clk); #1;
        dp_sel = s;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        mdl[0] = 16'h0000; mdl[1] = 16'h0000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push_ptr("R2 copy0 reset");
        set_sel(1); push_ptr("R2 copy1 reset");
        set_sel(0);
        // R3 load, R1/R4 byte reads
        do_op(1, 16'h1234, 0, 8'h00, 8'h00, 0); push_ptr("R3 load");
        push_rd(8'h82, "R1 R4 low byte read");
        push_rd(8'h83, "R1 R4 high byte read");
        push_rd(8'h81, "R4 other address reads zero");
        // R6/R11 switch select, copy1 untouched
        set_sel(1); push_ptr("R11 R6 select copy1 combinational");
        do_op(0, 16'h0000, 1, 8'h82, 8'hAB, 0); push_ptr("R1 low byte write copy1");
        do_op(0, 16'h0000, 1, 8'h83, 8'hCD, 0); push_ptr("R1 high byte write copy1");
        push_rd(8'h83, "R4 high byte copy1");
        set_sel(0); push_ptr("R5 copy0 unchanged by copy1 writes");
        // R7 carry and wrap on copy0
        do_op(1, 16'h00FF, 0, 8'h00, 8'h00, 0);
        do_op(0, 16'h0000, 0, 8'h00, 8'h00, 1); push_ptr("R7 carry into high byte");
        do_op(1, 16'hFFFF, 0, 8'h00, 8'h00, 0);
        do_op(0, 16'h0000, 0, 8'h00, 8'h00, 1); push_ptr("R7 wrap to zero");
        set_sel(1); push_ptr("R5 copy1 unchanged by copy0 ops");
        // R8 load beats byte write
        do_op(1, 16'h5A5A, 1, 8'h82, 8'h11, 0); push_ptr("R8 load wins over byte write");
        // R9 byte write beats increment, load beats increment
        do_op(0, 16'h0000, 1, 8'h83, 8'h77, 1); push_ptr("R9 byte write wins over increment");
        do_op(1, 16'h0FFF, 0, 8'h00, 8'h00, 1); push_ptr("R9 load wins over increment");
        // R10 other addresses ignored
        do_op(0, 16'h0000, 1, 8'h81, 8'hEE, 0); push_ptr("R10 write to other address ignored");
        do_op(0, 16'h0000, 1, 8'h84, 8'hEE, 0);
        push_rd(8'h82, "R10 low byte unchanged");
        set_sel(0); push_ptr("R5 R11 copy0 after copy1 traffic");
        // R2 reset again clears both
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        mdl[0] = 16'h0000; mdl[1] = 16'h0000;
        push_ptr("R2 copy0 cleared by reset");
        set_sel(1); push_ptr("R2 copy1 cleared by reset");
        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule